// File: doc/BRIEF.md
# Parallel DAC Front End with Power Sequencing

This block sits between a sample producer and an 8-bit parallel-input converter. Samples arrive on a valid/ready stream. The block places them on a data bus next to a divided-down converter clock and an active-low select. It changes the bus only on the falling edge of that clock, so the converter sees stable data around every rising edge, where it captures. The converter's output follows a captured code one clock later.

The block also drives the converter's two power lines and its active-low reference enable. A small command port requests one of three modes: run, standby or shutdown. Standby and shutdown take effect on the next cycle. A run request from standby or shutdown first passes through a timed wake wait, and no samples are accepted during that wait. A request that arrives during the wait is held and applied when the wait ends. A status output reports the current mode and flags when the analog output carries a real sample after a wake.

Top module: `dacfe_ctrl`

## Requirements
- R1: While and after reset the block is in shutdown: `dac_pd`=1, `dac_en`=0, `dac_cs_n`=1, `dac_ref_en_n`=0, `st_mode`=2, `s_ready`=0, `st_out_valid`=0, `dac_data`=0, `dac_clk`=0.
- R2: `dac_clk` runs freely from reset release, toggling every HALF_CYC system cycles. Its period is 2*HALF_CYC cycles and it starts low.
- R3: Pin encoding by state: in run (`st_mode`=0) and waking (`st_mode`=3) the pins are `dac_pd`=0, `dac_en`=1, `dac_cs_n`=0. In standby (`st_mode`=1) they are `dac_pd`=0, `dac_en`=0, `dac_cs_n`=1. In shutdown (`st_mode`=2) they are `dac_pd`=1, `dac_en`=0, `dac_cs_n`=1.
- R4: `cmd_mode` codes are 0 = run, 1 = standby, 2 = shutdown and 3 = ignored (a write with 3 changes nothing). Outside a wake wait, a standby or shutdown write is visible in `st_mode` on the cycle after the write.
- R5: A run write in standby or shutdown puts the block in the waking state (`st_mode`=3) for exactly WAKE_CYC = (SYS_HZ/1e6)*WAKE_US system cycles, after which it enters run.
- R6: During a wake wait, accepted mode writes do not change `st_mode`. The last one is held, and at the end of the wait the block goes to that mode (run if none was written).
- R7: `s_ready` is high only in run, for exactly the one system cycle whose closing edge drives `dac_clk` low. A sample accepted at that edge appears on `dac_data` at the same edge. `dac_data` holds its value at every other time, including while `s_valid` is high outside run.
- R8: After entry into run, `st_out_valid` rises together with the second rising edge of `dac_clk` that follows the first accepted sample. It stays high while in run and clears on the cycle after the block leaves run.
- R9: Every accepted write (code 0 to 2) copies `cmd_ref_ext` to `dac_ref_en_n`: 1 selects an external reference and 0 selects the internal one. A code-3 write leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Sample from upstream |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample taken at this edge |
| cmd_wr | input | 1 | Mode command strobe |
| cmd_mode | input | 2 | Requested mode code |
| cmd_ref_ext | input | 1 | Reference choice carried with the command |
| dac_data | output | 8 | Parallel data bus to the converter |
| dac_clk | output | 1 | Converter clock |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_pd | output | 1 | Power-down line |
| dac_en | output | 1 | Converter enable line |
| dac_ref_en_n | output | 1 | Internal reference enable, active low |
| st_mode | output | 2 | Status: 0 run, 1 standby, 2 shutdown, 3 waking |
| st_out_valid | output | 1 | Analog output reflects a sample taken since wake |

## Verification
The stream path is driven with four kinds of input:
- A back-to-back ramp, which exposes lost or repeated samples.
- Alternating 0x55/0xAA codes with idle gaps, which show whether the bus holds across stalls or picks up bits from the idle input.
- The 0x00 and 0xFF extremes, which reveal stuck bits.
- A constant offer during standby, which must leave the bus untouched.

On the power side, the sequences cover:
- A direct wake, whose length is measured in cycles.
- A wake interrupted by two later requests, showing that the last one is held rather than applied at once.
- An ignored code 3, showing that neither mode nor reference selection moves.
- A direct standby-from-shutdown step.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_STBY = 2'd1,
        PM_OFF  = 2'd2,
        PM_WAKE = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        SP_IDLE   = 2'd0,
        SP_DRIVEN = 2'd1,
        SP_CAPT   = 2'd2,
        SP_DONE   = 2'd3
    } sp_stage_e;

    typedef struct packed {
        logic pd;
        logic en;
        logic cs_n;
    } pm_pins_t;

    localparam logic [1:0] CMD_NOP = 2'd3;

    function automatic logic cmd_ok(input logic [1:0] code);
        return code != CMD_NOP;
    endfunction

    function automatic pm_state_e cmd_target(input logic [1:0] code);
        case (code)
            2'd1:    return PM_STBY;
            2'd2:    return PM_OFF;
            default: return PM_RUN;
        endcase
    endfunction

    function automatic pm_pins_t pins_of(input pm_state_e st);
        pm_pins_t p;
        case (st)
            PM_RUN, PM_WAKE: p = '{pd: 1'b0, en: 1'b1, cs_n: 1'b0};
            PM_STBY:         p = '{pd: 1'b0, en: 1'b0, cs_n: 1'b1};
            default:         p = '{pd: 1'b1, en: 1'b0, cs_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dacfe_clkgen.sv
module dacfe_clkgen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic dac_clk,
    output logic fall_evt,
    output logic rise_evt
);
    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

    logic [HC_W-1:0] hcnt_q;
    logic            clk_q;
    logic            last_ph;

    assign last_ph  = (hcnt_q == HC_LAST);
    assign fall_evt = clk_q && last_ph;
    assign rise_evt = !clk_q && last_ph;
    assign dac_clk  = clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
            clk_q  <= 1'b0;
        end else if (last_ph) begin
            hcnt_q <= '0;
            clk_q  <= ~clk_q;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dacfe_pwr_fsm.sv
module dacfe_pwr_fsm
    import dacfe_pkg::*;
#(
    parameter int WAKE_CYC = 6250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_mode,
    input  logic       cmd_ref_ext,
    output pm_state_e  state,
    output logic       ref_en_n
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] WAIT_LOAD = CW'(WAKE_CYC - 1);

    pm_state_e     st_q, pend_q, req;
    logic [CW-1:0] wcnt_q;
    logic          ref_q;
    logic          acc;

    assign acc      = cmd_wr && cmd_ok(cmd_mode);
    assign req      = cmd_target(cmd_mode);
    assign state    = st_q;
    assign ref_en_n = ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PM_OFF;
            pend_q <= PM_RUN;
            wcnt_q <= '0;
            ref_q  <= 1'b0;
        end else begin
            if (acc) ref_q <= cmd_ref_ext;
            case (st_q)
                PM_RUN: begin
                    if (acc && req != PM_RUN) st_q <= req;
                end
                PM_STBY, PM_OFF: begin
                    if (acc) begin
                        if (req == PM_RUN) begin
                            st_q   <= PM_WAKE;
                            wcnt_q <= WAIT_LOAD;
                            pend_q <= PM_RUN;
                        end else begin
                            st_q <= req;
                        end
                    end
                end
                default: begin
                    if (wcnt_q == '0) begin
                        st_q <= acc ? req : pend_q;
                    end else begin
                        wcnt_q <= wcnt_q - 1'b1;
                        if (acc) pend_q <= req;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dacfe_sample_path.sv
module dacfe_sample_path
    import dacfe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              fall_evt,
    input  logic              rise_evt,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] dac_data,
    output logic              out_valid
);
    sp_stage_e         stage_q;
    logic [DATA_W-1:0] data_q;
    logic              ov_q;
    logic              take;

    assign s_ready   = run && fall_evt;
    assign take      = s_ready && s_valid;
    assign dac_data  = data_q;
    assign out_valid = ov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            stage_q <= SP_IDLE;
            ov_q    <= 1'b0;
        end else begin
            if (take) data_q <= s_data;
            if (!run) begin
                stage_q <= SP_IDLE;
                ov_q    <= 1'b0;
            end else begin
                case (stage_q)
                    SP_IDLE:   if (take) stage_q <= SP_DRIVEN;
                    SP_DRIVEN: if (rise_evt) stage_q <= SP_CAPT;
                    SP_CAPT: begin
                        if (rise_evt) begin
                            stage_q <= SP_DONE;
                            ov_q    <= 1'b1;
                        end
                    end
                    default: stage_q <= SP_DONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
    import dacfe_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SYS_HZ   = 125_000_000,
    parameter int WAKE_US  = 50,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_mode,
    input  logic              cmd_ref_ext,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_clk,
    output logic              dac_cs_n,
    output logic              dac_pd,
    output logic              dac_en,
    output logic              dac_ref_en_n,
    output logic [1:0]        st_mode,
    output logic              st_out_valid
);
    localparam int WAKE_CYC = (SYS_HZ / 1_000_000) * WAKE_US;

    pm_state_e state;
    pm_pins_t  pins;
    logic      fall_evt, rise_evt;

    dacfe_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk(clk), .rst(rst), .dac_clk(dac_clk),
        .fall_evt(fall_evt), .rise_evt(rise_evt)
    );

    dacfe_pwr_fsm #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
        .cmd_ref_ext(cmd_ref_ext), .state(state), .ref_en_n(dac_ref_en_n)
    );

    dacfe_sample_path #(.DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst(rst), .run(state == PM_RUN),
        .fall_evt(fall_evt), .rise_evt(rise_evt),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .dac_data(dac_data), .out_valid(st_out_valid)
    );

    assign pins     = pins_of(state);
    assign dac_pd   = pins.pd;
    assign dac_en   = pins.en;
    assign dac_cs_n = pins.cs_n;
    assign st_mode  = state;
endmodule

// File: rtl/dacfe_ctrl_chk.sv
module dacfe_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] s_data,
    input logic              s_valid,
    input logic              s_ready,
    input logic              cmd_wr,
    input logic [1:0]        cmd_mode,
    input logic [DATA_W-1:0] dac_data,
    input logic              dac_clk,
    input logic              dac_cs_n,
    input logic              dac_pd,
    input logic              dac_en,
    input logic [1:0]        st_mode,
    input logic              st_out_valid
);
    // R3
    off_pins_chk: assert property (@(posedge clk) disable iff (rst)
        st_mode == 2'd2 |-> dac_pd && !dac_en && dac_cs_n);

    // R3
    on_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (st_mode == 2'd0 || st_mode == 2'd3) |-> !dac_pd && dac_en && !dac_cs_n);

    // R7
    ready_when_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> st_mode == 2'd0 && dac_clk);

    // R7
    data_load_chk: assert property (@(posedge clk) disable iff (rst)
        (s_ready && s_valid) |=> dac_data == $past(s_data) && !dac_clk);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(s_ready && s_valid) |=> $stable(dac_data));

    // R8
    ov_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_out_valid) |-> $rose(dac_clk) && st_mode == 2'd0);

    // R4
    stby_now_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_mode == 2'd1 && st_mode != 2'd3) |=> st_mode == 2'd1);
endmodule

bind dacfe_ctrl dacfe_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .dac_data(dac_data), .dac_clk(dac_clk), .dac_cs_n(dac_cs_n),
    .dac_pd(dac_pd), .dac_en(dac_en), .st_mode(st_mode),
    .st_out_valid(st_out_valid)
);

// File: tb/dacfe_ctrl_test.sv
module dacfe_ctrl_test;
    localparam int H    = 2;
    localparam int SYS  = 125_000_000;
    localparam int WUS  = 50;
    localparam int WCYC = (SYS / 1_000_000) * WUS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [1:0] cmd_mode = '0;
    logic       cmd_ref_ext = 1'b0;
    logic       s_ready, dac_clk, dac_cs_n, dac_pd, dac_en, dac_ref_en_n, st_out_valid;
    logic [7:0] dac_data;
    logic [1:0] st_mode;

    dacfe_ctrl #(.DATA_W(8), .SYS_HZ(SYS), .WAKE_US(WUS), .HALF_CYC(H)) uut (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .cmd_wr(cmd_wr), .cmd_mode(cmd_mode), .cmd_ref_ext(cmd_ref_ext),
        .dac_data(dac_data), .dac_clk(dac_clk), .dac_cs_n(dac_cs_n),
        .dac_pd(dac_pd), .dac_en(dac_en), .dac_ref_en_n(dac_ref_en_n),
        .st_mode(st_mode), .st_out_valid(st_out_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int         m_n, m_st, m_pend, m_wleft, m_stage;
    logic       m_ref, m_ov;
    logic [7:0] m_data;
    bit         m_live = 0;
    bit         e_clk, e_last, e_fall, e_rise, e_rdy, e_ok;

    always @(posedge clk) begin
        if (rst) begin
            m_n = 0; m_st = 2; m_pend = 0; m_wleft = 0; m_stage = 0;
            m_ref = 0; m_ov = 0; m_data = '0; m_live = 1;
        end else begin
            e_clk  = ((m_n / H) % 2) == 1;
            e_last = (m_n % H) == H - 1;
            e_fall = e_clk && e_last;
            e_rise = !e_clk && e_last;
            e_rdy  = (m_st == 0) && e_fall;
            e_ok   = cmd_wr && cmd_mode != 2'd3;
            if (e_rdy && s_valid) m_data = s_data;
            if (m_st != 0) begin
                m_stage = 0; m_ov = 0;
            end else if (m_stage == 0 && e_rdy && s_valid) m_stage = 1;
            else if (m_stage == 1 && e_rise) m_stage = 2;
            else if (m_stage == 2 && e_rise) begin m_stage = 3; m_ov = 1; end
            if (e_ok) m_ref = cmd_ref_ext;
            if (m_st == 0) begin
                if (e_ok && cmd_mode != 0) m_st = int'(cmd_mode);
            end else if (m_st == 3) begin
                if (m_wleft == 0) m_st = e_ok ? int'(cmd_mode) : m_pend;
                else begin
                    m_wleft--;
                    if (e_ok) m_pend = int'(cmd_mode);
                end
            end else if (e_ok) begin
                if (cmd_mode == 0) begin m_st = 3; m_wleft = WCYC - 1; m_pend = 0; end
                else m_st = int'(cmd_mode);
            end
            m_n++;
        end
    end

    always @(negedge clk) begin
        if (m_live && !rst) begin
            check("R2", "dac_clk", dac_clk, (m_n / H) % 2);
            check("R7", "s_ready", s_ready,
                  (m_st == 0 && ((m_n / H) % 2) == 1 && (m_n % H) == H - 1) ? 1 : 0);
            check("R7", "dac_data", dac_data, m_data);
            check("R4", "st_mode", st_mode, m_st);
            check("R3", "dac_pd", dac_pd, m_st == 2 ? 1 : 0);
            check("R3", "dac_en", dac_en, (m_st == 0 || m_st == 3) ? 1 : 0);
            check("R3", "dac_cs_n", dac_cs_n, (m_st == 0 || m_st == 3) ? 0 : 1);
            check("R9", "dac_ref_en_n", dac_ref_en_n, m_ref);
            check("R8", "st_out_valid", st_out_valid, m_ov);
        end
    end

    task automatic cmd(input logic [1:0] mode, input logic ref_ext);
        cmd_wr = 1'b1; cmd_mode = mode; cmd_ref_ext = ref_ext;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        s_data = d; s_valid = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (s_ready) begin
                @(negedge clk);
                s_valid = 1'b0;
                return;
            end
            @(negedge clk);
        end
        s_valid = 1'b0;
    endtask

    task automatic wake_measure(input string tag);
        int n = 0;
        while (st_mode == 2'd3 && n < WCYC + 10) begin
            n++;
            @(negedge clk);
        end
        check(tag, "wake length", n, WCYC);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "reset pd", dac_pd, 1);
        check("R1", "reset en", dac_en, 0);
        check("R1", "reset cs_n", dac_cs_n, 1);
        check("R1", "reset ref_en_n", dac_ref_en_n, 0);
        check("R1", "reset mode", st_mode, 2);
        check("R1", "reset ready/ov/clk/data", {s_ready, st_out_valid, dac_clk, dac_data}, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        cmd(2'd0, 1'b0);
        check("R5", "wake entered", st_mode, 3);
        wake_measure("R5");
        check("R5", "run after wake", st_mode, 0);

        // first sample and output-valid timing
        send(8'h11);
        begin
            int rises = 0;
            logic prev = dac_clk;
            for (int i = 0; i < 20 && !st_out_valid; i++) begin
                @(negedge clk);
                if (dac_clk && !prev) rises++;
                prev = dac_clk;
            end
            check("R8", "rises before valid", rises, 2);
        end

        for (int i = 0; i < 16; i++) send(8'(i));
        for (int i = 0; i < 8; i++) begin
            send((i % 2) ? 8'hAA : 8'h55);
            repeat (3) @(negedge clk);
        end
        send(8'h00); send(8'hFF); send(8'h00); send(8'hFF);

        cmd(2'd1, 1'b0);
        check("R4", "standby next cycle", st_mode, 1);
        @(negedge clk);
        check("R8", "valid cleared", st_out_valid, 0);
        s_data = 8'h3C; s_valid = 1'b1;
        repeat (20) @(negedge clk);
        check("R7", "bus held in standby", dac_data, 8'hFF);
        s_valid = 1'b0;

        cmd(2'd0, 1'b1);
        check("R9", "external ref", dac_ref_en_n, 1);
        repeat (10) @(negedge clk);
        cmd(2'd1, 1'b1);
        cmd(2'd2, 1'b1);
        check("R6", "still waking", st_mode, 3);
        begin
            int n = 0;
            while (st_mode == 2'd3 && n < WCYC + 10) begin n++; @(negedge clk); end
        end
        check("R6", "held request applied", st_mode, 2);

        cmd(2'd3, 1'b0);
        check("R4", "code 3 mode unchanged", st_mode, 2);
        check("R9", "code 3 ref unchanged", dac_ref_en_n, 1);

        cmd(2'd1, 1'b0);
        check("R4", "off to standby", st_mode, 1);
        check("R9", "internal ref", dac_ref_en_n, 0);

        cmd(2'd0, 1'b0);
        wake_measure("R5");
        for (int i = 0; i < 6; i++) send((i % 2) ? 8'hFF : 8'h00);
        cmd(2'd2, 1'b0);
        check("R4", "run to shutdown", st_mode, 2);
        repeat (5) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule